// File: doc/BRIEF.md
# FIFO Ready Indicator Generator

This block turns the fill state of one serial channel's receive and transmit FIFOs into two active-low handshake outputs. A DMA engine or polling host watches these outputs to decide when to move data. The receive indicator goes low once enough data has built up, or when the receive path reports that data has sat idle too long. The transmit indicator goes low once enough free slots have opened up.

Each indicator is a registered set/clear flag, and different conditions set and clear it. Once asserted, the receive indicator stays low until the receive FIFO drains to empty or an error shows up in it. A falling count alone does not release it. Once asserted, the transmit indicator stays low until the transmit FIFO is full. In any cycle where both the set and the clear condition hold, the clear wins. The FIFOs, the idle-time counter and the error detection sit outside the block and feed it through its inputs. Both trigger levels are programmable for a FIFO of 1 to DEPTH entries.

Top module: `fifo_ready_gen`

## Requirements
- R1: One clock edge after rx_level is nonzero and reaches the effective receive trigger (rx_level >= trigger), with no error, rx_ready_n is 0.
- R2: One clock edge after a cycle where rx_timeout is 1 and rx_level is nonzero with no error, rx_ready_n is 0, whatever the level.
- R3: One clock edge after a cycle with rx_level equal to 0, rx_ready_n is 1.
- R4: One clock edge after a cycle with rx_err equal to 1, rx_ready_n is 1.
- R5: When a receive set condition (R1 or R2) and a receive clear condition (R3 or R4) hold in the same cycle, rx_ready_n is 1 after the edge.
- R6: One clock edge after tx_space reaches the effective transmit trigger (tx_space >= trigger) with tx_full equal to 0, tx_ready_n is 0.
- R7: One clock edge after a cycle with tx_full equal to 1, tx_ready_n is 1, even if tx_space meets the trigger in that cycle.
- R8: In a cycle with neither a set nor a clear condition for an indicator, that indicator keeps its previous value. This covers a level that falls but stays above 0, and free space that drops below the trigger without the FIFO being full.
- R9: Reset is synchronous and active low. One edge after rst_n is 0, rx_ready_n is 1 (receive side empty) and tx_ready_n is 0 (transmit side free).
- R10: A programmed trigger of 0 acts as a trigger of 1, and a trigger above DEPTH (64 by default) acts as DEPTH. Both trigger inputs follow this rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_level | input | 7 | Entries held in the receive FIFO |
| rx_trig | input | 7 | Programmed receive trigger level |
| rx_timeout | input | 1 | Receive idle-timeout event |
| rx_err | input | 1 | An error is present in the receive FIFO |
| tx_space | input | 7 | Free entries in the transmit FIFO |
| tx_trig | input | 7 | Programmed transmit trigger level |
| tx_full | input | 1 | Transmit FIFO is full |
| rx_ready_n | output | 1 | Receive ready, active low |
| tx_ready_n | output | 1 | Transmit ready, active low |

## Verification
The embedded properties check the following on every cycle:
- each set and clear rule one edge later;
- the rule that the clear wins a tie;
- the hold behaviour when no condition is active;
- the out-of-range trigger mapping, checked against the raw port values.

Some behaviour only the bench's scenarios can show:
- hysteresis across long sequences, such as a level that climbs past the trigger, falls back, and must keep the indicator low until the FIFO is empty;
- the interplay of random levels, triggers and events.

The bench's cycle-by-cycle reference model covers both.

// File: rtl/frg_pkg.sv
// Package: shared types for the FIFO ready indicator generator.
// Assumes: none; holds only type definitions.
package frg_pkg;

    // State of one ready flag: released (pin high) or active (pin low).
    typedef enum logic {
        FLAG_RELEASED = 1'b0,
        FLAG_ACTIVE   = 1'b1
    } flag_state_e;

endpackage

// File: rtl/frg_trig_norm.sv
// Module: frg_trig_norm
// Maps a programmed trigger level onto the legal range 1..DEPTH.
// A value of 0 becomes 1, and a value above DEPTH becomes DEPTH.
// Assumes: CNT_W is wide enough to hold DEPTH.
module frg_trig_norm #(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] raw_i,
    output logic [CNT_W-1:0] eff_o
);

    localparam logic [CNT_W-1:0] MAX_LVL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] MIN_LVL = CNT_W'(1);

    // Clamp the raw trigger into 1..DEPTH.
    always_comb begin
        if (raw_i == '0)
            eff_o = MIN_LVL;
        else if (raw_i > MAX_LVL)
            eff_o = MAX_LVL;
        else
            eff_o = raw_i;
    end

endmodule

// File: rtl/frg_flag.sv
// Module: frg_flag
// Registered set/clear flag. In a cycle where both requests are high,
// the clear request wins. RESET_ACTIVE selects the state after reset.
// Assumes: set_i and clr_i are synchronous to clk.
module frg_flag
    import frg_pkg::*;
#(
    parameter bit RESET_ACTIVE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic active_o
);

    localparam flag_state_e RST_STATE = RESET_ACTIVE ? FLAG_ACTIVE : FLAG_RELEASED;

    flag_state_e state_q;
    flag_state_e state_d;

    // Next-state choice: clear first, then set, otherwise hold.
    always_comb begin
        if (clr_i)
            state_d = FLAG_RELEASED;
        else if (set_i)
            state_d = FLAG_ACTIVE;
        else
            state_d = state_q;
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= RST_STATE;
        else
            state_q <= state_d;
    end

    assign active_o = (state_q == FLAG_ACTIVE);

    // R5/R7: a clear request always releases the flag, even when set is also high.
    p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !active_o)
        else $error("p_clear_wins_r5 failed");

    // R8: the flag holds its value when no request is present.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(active_o))
        else $error("p_hold_r8 failed");

endmodule

// File: rtl/fifo_ready_gen.sv
// Module: fifo_ready_gen (top)
// Generates the active-low receive-ready and transmit-ready outputs for one
// channel from its FIFO fill state.
// Assumes: level, space and trigger inputs are synchronous to clk.
// Assumes: the level and space inputs never exceed DEPTH.
module fifo_ready_gen #(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             rx_timeout,
    input  logic             rx_err,
    input  logic [CNT_W-1:0] tx_space,
    input  logic [CNT_W-1:0] tx_trig,
    input  logic             tx_full,
    output logic             rx_ready_n,
    output logic             tx_ready_n
);

    localparam int NUM_DIR = 2;   // index 0 = receive, index 1 = transmit
    localparam int RX_IDX  = 0;
    localparam int TX_IDX  = 1;

    logic [CNT_W-1:0] raw_trig [NUM_DIR];
    logic [CNT_W-1:0] eff_trig [NUM_DIR];
    logic rx_set, rx_clr, tx_set, tx_clr;
    logic rx_active, tx_active;

    assign raw_trig[RX_IDX] = rx_trig;
    assign raw_trig[TX_IDX] = tx_trig;

    // One trigger normaliser per direction.
    for (genvar g = 0; g < NUM_DIR; g++) begin : g_norm
        frg_trig_norm #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_norm (
            .raw_i (raw_trig[g]),
            .eff_o (eff_trig[g])
        );
    end

    // Receive set and clear conditions.
    always_comb begin
        rx_set = rx_timeout || (rx_level >= eff_trig[RX_IDX]);
        rx_clr = (rx_level == '0) || rx_err;
    end

    // Transmit set and clear conditions.
    always_comb begin
        tx_set = (tx_space >= eff_trig[TX_IDX]);
        tx_clr = tx_full;
    end

    frg_flag #(.RESET_ACTIVE(1'b0)) u_rx_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (rx_set),
        .clr_i    (rx_clr),
        .active_o (rx_active)
    );

    frg_flag #(.RESET_ACTIVE(1'b1)) u_tx_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (tx_set),
        .clr_i    (tx_clr),
        .active_o (tx_active)
    );

    assign rx_ready_n = ~rx_active;
    assign tx_ready_n = ~tx_active;

    // R1: an in-range trigger that is reached asserts receive-ready.
    p_rx_trig_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_err && rx_level != '0 && rx_trig != '0 && int'(rx_trig) <= DEPTH
         && rx_level >= rx_trig) |=> !rx_ready_n)
        else $error("p_rx_trig_r1 failed");

    // R2: a timeout event asserts receive-ready regardless of level.
    p_rx_tmo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_timeout && !rx_err && rx_level != '0) |=> !rx_ready_n)
        else $error("p_rx_tmo_r2 failed");

    // R3: an empty receive FIFO releases receive-ready.
    p_rx_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0) |=> rx_ready_n)
        else $error("p_rx_empty_r3 failed");

    // R4: a receive error releases receive-ready.
    p_rx_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |=> rx_ready_n)
        else $error("p_rx_err_r4 failed");

    // R6: enough free space asserts transmit-ready.
    p_tx_space_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_full && tx_trig != '0 && int'(tx_trig) <= DEPTH
         && tx_space >= tx_trig) |=> !tx_ready_n)
        else $error("p_tx_space_r6 failed");

    // R7: a full transmit FIFO releases transmit-ready.
    p_tx_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |=> tx_ready_n)
        else $error("p_tx_full_r7 failed");

    // R9: the reset values are receive released and transmit asserted.
    p_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (rx_ready_n && !tx_ready_n))
        else $error("p_reset_r9 failed");

    // R10: a trigger of 0 acts as 1, so a single entry sets receive-ready.
    p_rx_zero_trig_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_trig == '0 && rx_level != '0 && !rx_err) |=> !rx_ready_n)
        else $error("p_rx_zero_trig_r10 failed");

    // R10: an oversized trigger acts as DEPTH, so a fully free FIFO sets transmit-ready.
    p_tx_big_trig_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tx_trig) > DEPTH && int'(tx_space) == DEPTH && !tx_full) |=> !tx_ready_n)
        else $error("p_tx_big_trig_r10 failed");

endmodule

// File: tb/fifo_ready_gen_bench.sv
`timescale 1ns/1ps
// Bench for fifo_ready_gen: a behavioural reference model advanced and
// compared against the outputs on every clock.
module fifo_ready_gen_bench;

    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] rx_level = '0, rx_trig = '0, tx_space = '0, tx_trig = '0;
    logic       rx_timeout = 1'b0, rx_err = 1'b0, tx_full = 1'b0;
    logic       rx_ready_n, tx_ready_n;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;
    bit  exp_rx_n = 1'b1;
    bit  exp_tx_n = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    fifo_ready_gen #(.DEPTH(DEPTH)) u_fifo_ready_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_level   (rx_level),
        .rx_trig    (rx_trig),
        .rx_timeout (rx_timeout),
        .rx_err     (rx_err),
        .tx_space   (tx_space),
        .tx_trig    (tx_trig),
        .tx_full    (tx_full),
        .rx_ready_n (rx_ready_n),
        .tx_ready_n (tx_ready_n)
    );

    // Map a programmed trigger onto 1..DEPTH (R10).
    function automatic int eff(input int t);
        if (t == 0) return 1;
        if (t > DEPTH) return DEPTH;
        return t;
    endfunction

    // Drive one cycle of inputs, advance the model, and compare after the edge.
    task automatic step(input bit rst, input int lvl, input int rtg, input bit tmo,
                        input bit err, input int spc, input int ttg, input bit full);
        string rtag, ttag;
        bit rset, rclr, tset;
        @(negedge clk);
        rst_n = rst; rx_level = 7'(lvl); rx_trig = 7'(rtg); rx_timeout = tmo;
        rx_err = err; tx_space = 7'(spc); tx_trig = 7'(ttg); tx_full = full;
        rset = tmo || (lvl >= eff(rtg));
        rclr = (lvl == 0) || err;
        tset = (spc >= eff(ttg));
        if (!rst) begin
            exp_rx_n = 1'b1; exp_tx_n = 1'b0; rtag = "R9"; ttag = "R9";
        end else begin
            if (rclr) begin
                exp_rx_n = 1'b1;
                rtag = rset ? "R5" : (lvl == 0 ? "R3" : "R4");
            end else if (rset) begin
                exp_rx_n = 1'b0;
                if (lvl >= eff(rtg)) rtag = (rtg == 0 || rtg > DEPTH) ? "R10" : "R1";
                else rtag = "R2";
            end else rtag = "R8";
            if (full) begin
                exp_tx_n = 1'b1; ttag = "R7";
            end else if (tset) begin
                exp_tx_n = 1'b0;
                ttag = (ttg == 0 || ttg > DEPTH) ? "R10" : "R6";
            end else ttag = "R8";
        end
        @(posedge clk);
        #1;
        n_checks++;
        if (rx_ready_n !== exp_rx_n) begin
            n_fails++;
            $display("FAIL %s rx_ready_n actual=%b expected=%b", rtag, rx_ready_n, exp_rx_n);
        end
        n_checks++;
        if (tx_ready_n !== exp_tx_n) begin
            n_fails++;
            $display("FAIL %s tx_ready_n actual=%b expected=%b", ttag, tx_ready_n, exp_tx_n);
        end
    endtask

    initial begin
        // R9: reset state
        step(0, 5, 4, 1, 0, 0, 16, 1);
        step(0, 0, 4, 0, 0, 0, 16, 0);
        // R3 empty, R6 fully free
        step(1, 0, 4, 0, 0, 64, 16, 0);
        // R8 below trigger, R1 reach trigger, R8 fall but not empty, R3 empty
        step(1, 3, 4, 0, 0, 64, 16, 0);
        step(1, 4, 4, 0, 0, 64, 16, 0);
        step(1, 2, 4, 0, 0, 64, 16, 0);
        step(1, 0, 4, 0, 0, 64, 16, 0);
        // R2 timeout below trigger, then hold, R4 error, R5 error beats timeout
        step(1, 1, 8, 1, 0, 64, 16, 0);
        step(1, 1, 8, 0, 0, 64, 16, 0);
        step(1, 1, 8, 0, 1, 64, 16, 0);
        step(1, 8, 8, 1, 1, 64, 16, 0);
        // R5 empty beats timeout
        step(1, 3, 2, 0, 0, 64, 16, 0);
        step(1, 0, 2, 1, 0, 64, 16, 0);
        // R10 trigger 0 acts as 1; trigger 100 acts as 64
        step(1, 1, 0, 0, 0, 64, 16, 0);
        step(1, 1, 0, 0, 1, 64, 16, 0);
        step(1, 63, 100, 0, 0, 64, 16, 0);
        step(1, 64, 100, 0, 0, 64, 16, 0);
        // R7 full, R8 below trigger, R6 reach, R7 full beats set
        step(1, 64, 100, 0, 0, 0, 16, 1);
        step(1, 64, 100, 0, 0, 10, 16, 0);
        step(1, 64, 100, 0, 0, 16, 16, 0);
        step(1, 64, 100, 0, 0, 5, 16, 0);
        step(1, 64, 100, 0, 0, 20, 16, 1);
        // R10 transmit: trigger 0 and trigger 127
        step(1, 64, 100, 0, 0, 1, 0, 0);
        step(1, 64, 100, 0, 0, 0, 127, 1);
        step(1, 64, 100, 0, 0, 63, 127, 0);
        step(1, 64, 100, 0, 0, 64, 127, 0);
        // Mixed random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            step(($urandom_range(0, 99) != 0),
                 ($urandom_range(0, 5) == 0) ? 0 : $urandom_range(1, DEPTH),
                 $urandom_range(0, 127),
                 ($urandom_range(0, 9) == 0),
                 ($urandom_range(0, 14) == 0),
                 $urandom_range(0, DEPTH),
                 $urandom_range(0, 127),
                 ($urandom_range(0, 9) == 0));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog (R1) actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule